// File: doc/BRIEF.md
# Clock-Synchronous Serial Transceiver

This block moves eight-bit words over a serial data pair that shares one transfer clock. A host writes a word into the transmit buffer. When the shift engine is idle and the buffer holds data, the engine loads the word and clocks it out on `sdo`. During the same eight clock periods it samples `sdi` into the receive shifter. At the end of the word the received byte lands in the receive buffer and a completion flag is raised for the host.

The transfer clock either comes from an internal divider of the system clock or arrives on `sclk_in` from another device. When it comes from outside, it is synchronized before use. The idle clock level and the active edges depend on a polarity control, and the bit order is selectable. An inversion control complements data in both directions. A continuous-receive control lets a read of the receive buffer start the next word with no dummy write. When the internal clock is used, the transfer clock can be steered to either of two output pins.

Top module: `sync_serial_xcvr`

## Requirements
- R1: After reset `tx_empty` is 1, `rx_full` and `overrun` are 0, `sdo` is 1, and both clock pins sit at the idle level.
- R2: A `wr_tx` strobe stores `wr_data` and drives `tx_empty` to 0 on the next cycle. When the engine is idle and the buffer holds data, the word is loaded into the shifter and `tx_empty` returns to 1.
- R3: With `cfg_ckpol`=0 the clock idles high, `sdo` changes only on falling clock edges and `sdi` is sampled on rising edges. With `cfg_ckpol`=1 the clock idles low, `sdo` changes on rising edges and `sdi` is sampled on falling edges.
- R4: With `cfg_msb_first`=0 bits travel in the order bit 0 to bit 7. With 1 they travel bit 7 to bit 0. The same order applies to both directions.
- R5: With `cfg_invert`=1 each transmitted bit is the complement of the written bit. `rx_data` shows the complement of the received bits.
- R6: In internal-clock mode every half period of the transfer clock lasts `cfg_div`+1 system clock cycles.
- R7: After the eighth received bit, the word is placed in the receive buffer and `rx_full` becomes 1. A `rd_rx` strobe clears `rx_full`.
- R8: If a word completes while `rx_full` is still 1, `overrun` becomes 1. A `rd_rx` strobe clears `overrun`.
- R9: With `cfg_cont_rx`=1, a `rd_rx` strobe drives `tx_empty` to 0, so the next word starts and the old buffer contents are sent again. With `cfg_cont_rx`=0 a read leaves `tx_empty` unchanged.
- R10: In internal-clock mode with `cfg_multi_pin`=1 and `cfg_alt_sel`=1, the clock appears on `sclk_alt` and `sclk_pri` rests at the idle level. In every other internal-clock case the clock appears on `sclk_pri` and `sclk_alt` rests at the idle level.
- R11: With `cfg_ext_clk`=1 both clock pins rest at the idle level. Shifting follows the synchronized edges of `sclk_in` under the edge and order rules above. Edges that arrive while the transmit buffer is empty and the engine is idle are ignored, so no word is received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_ext_clk | input | 1 | 1: transfer clock from `sclk_in`; 0: internal divider |
| cfg_ckpol | input | 1 | Clock polarity / edge select |
| cfg_msb_first | input | 1 | Bit order select |
| cfg_invert | input | 1 | Data inversion in both directions |
| cfg_cont_rx | input | 1 | Continuous-receive enable |
| cfg_multi_pin | input | 1 | Enables clock steering between two pins |
| cfg_alt_sel | input | 1 | Chooses the alternate clock pin when steering is enabled |
| cfg_div | input | DIV_W | Half-period divisor minus one |
| wr_tx | input | 1 | Transmit buffer write strobe |
| wr_data | input | DATA_W | Word to transmit |
| rd_rx | input | 1 | Receive buffer read strobe |
| rx_data | output | DATA_W | Receive buffer contents, inverted when enabled |
| tx_empty | output | 1 | Transmit buffer empty flag |
| rx_full | output | 1 | Receive complete flag |
| overrun | output | 1 | Word lost because the previous one was unread |
| sclk_in | input | 1 | External transfer clock |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |
| sclk_pri | output | 1 | Primary transfer clock pin |
| sclk_alt | output | 1 | Alternate transfer clock pin |

## Verification
The bench builds the block with its defaults: an eight-bit word, an eight-bit divisor and a two-stage synchronizer. Because the divisor is a run-time input, the bench can use small values from 0 to 4. These give one-cycle half periods, where a single-cycle timing slip between the divider and the shift engine would be exposed, and keep each frame short enough to sweep both polarities, both bit orders, inversion and all pin-steering cases. Two synchronizer stages make the delay on external clock edges short and fixed, so the bench can place `sclk_in` edges six cycles apart and still sample `sdo` safely.

// File: rtl/sxc_pkg.sv
package sxc_pkg;
   typedef enum logic {ORDER_LSB = 1'b0, ORDER_MSB = 1'b1} order_t;

   function automatic logic idle_level(input logic pol);
      return ~pol;
   endfunction
endpackage

// File: rtl/sxc_clkdiv.sv
module sxc_clkdiv #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [DIV_W-1:0] div,
   output logic             lead_ev,
   output logic             trail_ev,
   output logic             act
);
   logic [DIV_W-1:0] cnt;
   logic             tick;

   always_comb begin
      tick     = run && (cnt == div);
      lead_ev  = tick && !act;
      trail_ev = tick && act;
   end

   always_ff @(posedge clk) begin
      if (!rst_n || !run) begin
         cnt <= '0;
         act <= 1'b0;
      end else if (tick) begin
         cnt <= '0;
         act <= ~act;
      end else begin
         cnt <= cnt + 1'b1;
      end
   end
endmodule

// File: rtl/sxc_edgesync.sv
module sxc_edgesync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_in,
   input  logic idle_lvl,
   output logic lead_ev,
   output logic trail_ev
);
   logic [STAGES:0] chain;
   logic            now_lvl, prev_lvl;

   generate
      for (genvar s = 0; s <= STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk) chain[0] <= rst_n ? pin_in : 1'b1;
         end else begin : g_next
            always_ff @(posedge clk) chain[s] <= rst_n ? chain[s-1] : 1'b1;
         end
      end
   endgenerate

   always_comb begin
      now_lvl  = chain[STAGES-1];
      prev_lvl = chain[STAGES];
      lead_ev  = (now_lvl != prev_lvl) && (now_lvl != idle_lvl);
      trail_ev = (now_lvl != prev_lvl) && (now_lvl == idle_lvl);
   end
endmodule

// File: rtl/sxc_shift.sv
module sxc_shift
   import sxc_pkg::*;
#(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_word,
   input  logic         msb_first,
   input  logic         lead_ev,
   input  logic         trail_ev,
   input  logic         sdi,
   output logic         busy,
   output logic         sdo,
   output logic         done,
   output logic [W-1:0] rx_next
);
   localparam int CW = $clog2(W);
   localparam logic [CW-1:0] LAST = CW'(W - 1);

   logic [W-1:0]  tx_sh, rx_sh;
   logic [CW-1:0] cnt;
   order_t        ord;

   always_comb begin
      ord     = order_t'(msb_first);
      rx_next = (ord == ORDER_MSB) ? {rx_sh[W-2:0], sdi} : {sdi, rx_sh[W-1:1]};
      done    = busy && trail_ev && (cnt == LAST);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy  <= 1'b0;
         sdo   <= 1'b1;
         tx_sh <= '0;
         rx_sh <= '0;
         cnt   <= '0;
      end else if (load) begin
         busy  <= 1'b1;
         tx_sh <= load_word;
         cnt   <= '0;
      end else if (busy) begin
         if (lead_ev) begin
            if (ord == ORDER_MSB) begin
               sdo   <= tx_sh[W-1];
               tx_sh <= tx_sh << 1;
            end else begin
               sdo   <= tx_sh[0];
               tx_sh <= tx_sh >> 1;
            end
         end
         if (trail_ev) begin
            rx_sh <= rx_next;
            if (cnt == LAST) begin
               busy <= 1'b0;
               cnt  <= '0;
            end else begin
               cnt <= cnt + 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/sync_serial_xcvr.sv
module sync_serial_xcvr
   import sxc_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int DIV_W       = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_ext_clk,
   input  logic              cfg_ckpol,
   input  logic              cfg_msb_first,
   input  logic              cfg_invert,
   input  logic              cfg_cont_rx,
   input  logic              cfg_multi_pin,
   input  logic              cfg_alt_sel,
   input  logic [DIV_W-1:0]  cfg_div,
   input  logic              wr_tx,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_rx,
   output logic [DATA_W-1:0] rx_data,
   output logic              tx_empty,
   output logic              rx_full,
   output logic              overrun,
   input  logic              sclk_in,
   input  logic              sdi,
   output logic              sdo,
   output logic              sclk_pri,
   output logic              sclk_alt
);
   generate
      if (DATA_W < 2) begin : g_bad_width
         $error("DATA_W must be at least 2");
      end
      if (DIV_W < 1) begin : g_bad_div
         $error("DIV_W must be at least 1");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
   endgenerate

   localparam logic [DATA_W-1:0] ALL_ONES = {DATA_W{1'b1}};

   logic [DATA_W-1:0] tx_buf, rx_buf, rx_next;
   logic              busy, start, xfer_done, idle_lvl, steer_alt;
   logic              int_lead, int_trail, int_act, ext_lead, ext_trail;
   logic              lead_ev, trail_ev, int_clk;

   always_comb begin
      idle_lvl  = idle_level(cfg_ckpol);
      start     = !busy && !tx_empty;
      steer_alt = !cfg_ext_clk && cfg_multi_pin && cfg_alt_sel;
      int_clk   = idle_lvl ^ int_act;
      lead_ev   = cfg_ext_clk ? ext_lead  : int_lead;
      trail_ev  = cfg_ext_clk ? ext_trail : int_trail;
      sclk_pri  = (!cfg_ext_clk && !steer_alt) ? int_clk : idle_lvl;
      sclk_alt  = steer_alt ? int_clk : idle_lvl;
      rx_data   = rx_buf ^ (cfg_invert ? ALL_ONES : '0);
   end

   sxc_clkdiv #(.DIV_W(DIV_W)) u_div (
      .clk(clk), .rst_n(rst_n), .run(busy && !cfg_ext_clk), .div(cfg_div),
      .lead_ev(int_lead), .trail_ev(int_trail), .act(int_act)
   );

   sxc_edgesync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .pin_in(sclk_in), .idle_lvl(idle_lvl),
      .lead_ev(ext_lead), .trail_ev(ext_trail)
   );

   sxc_shift #(.W(DATA_W)) u_shift (
      .clk(clk), .rst_n(rst_n), .load(start), .load_word(tx_buf),
      .msb_first(cfg_msb_first), .lead_ev(lead_ev), .trail_ev(trail_ev),
      .sdi(sdi), .busy(busy), .sdo(sdo), .done(xfer_done), .rx_next(rx_next)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tx_buf   <= '0;
         tx_empty <= 1'b1;
      end else begin
         if (start) tx_empty <= 1'b1;
         if (wr_tx) begin
            tx_buf   <= wr_data ^ (cfg_invert ? ALL_ONES : '0);
            tx_empty <= 1'b0;
         end
         if (rd_rx && cfg_cont_rx) tx_empty <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rx_buf  <= '0;
         rx_full <= 1'b0;
         overrun <= 1'b0;
      end else begin
         if (rd_rx) begin
            rx_full <= 1'b0;
            overrun <= 1'b0;
         end
         if (xfer_done) begin
            rx_buf  <= rx_next;
            rx_full <= 1'b1;
            if (rx_full && !rd_rx) overrun <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/sxc_checker.sv
module sxc_checker (
   input logic clk,
   input logic rst_n,
   input logic cfg_ext_clk,
   input logic cfg_ckpol,
   input logic cfg_cont_rx,
   input logic cfg_multi_pin,
   input logic cfg_alt_sel,
   input logic wr_tx,
   input logic rd_rx,
   input logic tx_empty,
   input logic rx_full,
   input logic overrun,
   input logic sdo,
   input logic sclk_pri,
   input logic sclk_alt,
   input logic lead_ev,
   input logic xfer_done
);
   a_r2_write_fills: assert property (@(posedge clk) disable iff (!rst_n)
      wr_tx |=> !tx_empty);

   a_r3_sdo_moves_on_lead: assert property (@(posedge clk) disable iff (!rst_n)
      !lead_ev |=> $stable(sdo));

   a_r7_done_sets_full: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_done |=> rx_full);

   a_r7_read_clears_full: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_rx && !xfer_done) |=> !rx_full);

   a_r8_overrun_on_unread: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_done && rx_full && !rd_rx) |=> overrun);

   a_r9_cont_rearm: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_rx && cfg_cont_rx) |=> !tx_empty);

   a_r10_pri_rests: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_ext_clk && cfg_multi_pin && cfg_alt_sel) |-> (sclk_pri == !cfg_ckpol));

   a_r10_alt_rests: assert property (@(posedge clk) disable iff (!rst_n)
      !(!cfg_ext_clk && cfg_multi_pin && cfg_alt_sel) |-> (sclk_alt == !cfg_ckpol));

   a_r11_ext_no_clock: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_ext_clk |-> (sclk_pri == !cfg_ckpol && sclk_alt == !cfg_ckpol));
endmodule

bind sync_serial_xcvr sxc_checker u_chk (
   .clk(clk), .rst_n(rst_n), .cfg_ext_clk(cfg_ext_clk), .cfg_ckpol(cfg_ckpol),
   .cfg_cont_rx(cfg_cont_rx), .cfg_multi_pin(cfg_multi_pin), .cfg_alt_sel(cfg_alt_sel),
   .wr_tx(wr_tx), .rd_rx(rd_rx), .tx_empty(tx_empty), .rx_full(rx_full),
   .overrun(overrun), .sdo(sdo), .sclk_pri(sclk_pri), .sclk_alt(sclk_alt),
   .lead_ev(lead_ev), .xfer_done(xfer_done)
);

// File: tb/sync_serial_xcvr_test.sv
module sync_serial_xcvr_test;
   localparam int CLK_PERIOD = 10;
   localparam int W = 8;
   localparam int DW = 8;
   localparam int NV = 6;
   // {tx, pattern, div, ckpol, msb_first, invert, multi_pin, alt_sel}
   localparam logic [28:0] VEC [NV] = '{
      {8'hA5, 8'h3C, 8'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
      {8'h81, 8'hC3, 8'd2, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1},
      {8'h5A, 8'h96, 8'd0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1},
      {8'hF0, 8'h0F, 8'd3, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0},
      {8'h12, 8'hED, 8'd1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1},
      {8'h7E, 8'h01, 8'd4, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0}
   };

   logic clk = 1'b0, rst_n = 1'b0;
   logic cfg_ext_clk = 0, cfg_ckpol = 0, cfg_msb_first = 0, cfg_invert = 0;
   logic cfg_cont_rx = 0, cfg_multi_pin = 0, cfg_alt_sel = 0;
   logic [DW-1:0] cfg_div = 8'd1;
   logic wr_tx = 0, rd_rx = 0, sclk_in = 1, sdi = 1;
   logic [W-1:0] wr_data = '0;
   logic [W-1:0] rx_data;
   logic tx_empty, rx_full, overrun, sdo, sclk_pri, sclk_alt;
   int checks = 0, fails = 0;

   sync_serial_xcvr uut (
      .clk(clk), .rst_n(rst_n), .cfg_ext_clk(cfg_ext_clk), .cfg_ckpol(cfg_ckpol),
      .cfg_msb_first(cfg_msb_first), .cfg_invert(cfg_invert), .cfg_cont_rx(cfg_cont_rx),
      .cfg_multi_pin(cfg_multi_pin), .cfg_alt_sel(cfg_alt_sel), .cfg_div(cfg_div),
      .wr_tx(wr_tx), .wr_data(wr_data), .rd_rx(rd_rx), .rx_data(rx_data),
      .tx_empty(tx_empty), .rx_full(rx_full), .overrun(overrun), .sclk_in(sclk_in),
      .sdi(sdi), .sdo(sdo), .sclk_pri(sclk_pri), .sclk_alt(sclk_alt)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic int widx(input int k);
      return cfg_msb_first ? W - 1 - k : k;
   endfunction

   task automatic host_write(input logic [W-1:0] d);
      @(negedge clk);
      wr_data = d;
      wr_tx   = 1'b1;
      @(negedge clk);
      wr_tx   = 1'b0;
      chk(tx_empty == 1'b0, "R2 write marks buffer full", tx_empty, 0);
   endtask

   task automatic host_read(output logic [W-1:0] v);
      @(negedge clk);
      v     = rx_data;
      rd_rx = 1'b1;
      @(negedge clk);
      rd_rx = 1'b0;
   endtask

   task automatic slave_frame(input logic [W-1:0] pat, output logic [W-1:0] got,
                              output int bad_gap, output int bad_idle, output bit tmo);
      logic idle, prev, cur, oth, sel;
      int bits, last_t, t;
      idle = !cfg_ckpol; prev = idle; got = '0;
      bad_gap = 0; bad_idle = 0; tmo = 0; bits = 0; last_t = -1; t = 0;
      while (bits < W) begin
         @(negedge clk);
         t++;
         if (t > 5000) begin tmo = 1; break; end
         sel = cfg_multi_pin && cfg_alt_sel;
         cur = sel ? sclk_alt : sclk_pri;
         oth = sel ? sclk_pri : sclk_alt;
         if (oth !== idle) bad_idle++;
         if (cur !== prev) begin
            if (last_t >= 0 && (t - last_t) != (int'(cfg_div) + 1)) bad_gap++;
            last_t = t;
            if (cur !== idle) sdi = pat[widx(bits)];
            else begin
               got[widx(bits)] = sdo;
               bits++;
            end
            prev = cur;
         end
      end
   endtask

   task automatic ext_frame(input logic [W-1:0] tx, input logic [W-1:0] pat,
                            output logic [W-1:0] got, output int bad_idle);
      logic idle;
      idle = !cfg_ckpol; got = '0; bad_idle = 0;
      sclk_in = idle;
      repeat (5) @(negedge clk);
      host_write(tx);
      repeat (3) @(negedge clk);
      for (int k = 0; k < W; k++) begin
         sclk_in = !idle;
         sdi = pat[widx(k)];
         for (int c = 0; c < 6; c++) begin
            @(negedge clk);
            if (sclk_pri !== idle || sclk_alt !== idle) bad_idle++;
         end
         got[widx(k)] = sdo;
         sclk_in = idle;
         for (int c = 0; c < 6; c++) begin
            @(negedge clk);
            if (sclk_pri !== idle || sclk_alt !== idle) bad_idle++;
         end
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      logic [W-1:0] got, got2, r, mask, tx, pat;
      logic [28:0] v;
      int bg, bi;
      bit tmo;

      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(tx_empty == 1'b1, "R1 tx_empty after reset", tx_empty, 1);
      chk(rx_full == 1'b0, "R1 rx_full after reset", rx_full, 0);
      chk(overrun == 1'b0, "R1 overrun after reset", overrun, 0);
      chk(sdo == 1'b1, "R1 sdo after reset", sdo, 1);
      chk(sclk_pri == 1'b1 && sclk_alt == 1'b1, "R1 clock pins idle", {sclk_pri, sclk_alt}, 2'b11);

      // table of frames: R3 R4 R5 R6 R7 R10
      for (int i = 0; i < NV; i++) begin
         v = VEC[i];
         tx = v[28:21]; pat = v[20:13]; cfg_div = v[12:5];
         cfg_ckpol = v[4]; cfg_msb_first = v[3]; cfg_invert = v[2];
         cfg_multi_pin = v[1]; cfg_alt_sel = v[0];
         mask = cfg_invert ? 8'hFF : 8'h00;
         @(negedge clk);
         host_write(tx);
         slave_frame(pat, got, bg, bi, tmo);
         chk(!tmo, "R3 frame completes", tmo, 0);
         chk(got == (tx ^ mask), "R4 R5 wire data", got, tx ^ mask);
         chk(bg == 0, "R6 half period length", bg, 0);
         chk(bi == 0, "R10 unselected pin idle", bi, 0);
         chk(rx_full == 1'b1, "R7 rx_full after eighth bit", rx_full, 1);
         host_read(r);
         chk(r == (pat ^ mask), "R5 R7 received word", r, pat ^ mask);
         chk(rx_full == 1'b0, "R7 read clears rx_full", rx_full, 0);
      end

      // R8 overrun
      cfg_div = 8'd1; cfg_ckpol = 0; cfg_msb_first = 0; cfg_invert = 0;
      cfg_multi_pin = 0; cfg_alt_sel = 0;
      host_write(8'h11);
      slave_frame(8'h5C, got, bg, bi, tmo);
      chk(overrun == 1'b0, "R8 no overrun on first word", overrun, 0);
      host_write(8'h22);
      slave_frame(8'hA3, got, bg, bi, tmo);
      chk(overrun == 1'b1, "R8 overrun on unread word", overrun, 1);
      chk(rx_data == 8'hA3, "R8 newest word kept", rx_data, 8'hA3);
      host_read(r);
      chk(overrun == 1'b0 && rx_full == 1'b0, "R8 read clears flags", {overrun, rx_full}, 0);

      // R9 continuous receive
      cfg_cont_rx = 1'b1;
      host_write(8'h3C);
      slave_frame(8'h81, got, bg, bi, tmo);
      host_read(r);
      chk(r == 8'h81, "R9 first word", r, 8'h81);
      chk(tx_empty == 1'b0, "R9 read re-arms transmit", tx_empty, 0);
      slave_frame(8'h42, got2, bg, bi, tmo);
      chk(!tmo, "R9 second frame without write", tmo, 0);
      chk(got2 == got, "R9 stale buffer resent", got2, got);
      chk(rx_full == 1'b1, "R9 second word received", rx_full, 1);
      cfg_cont_rx = 1'b0;
      host_read(r);
      chk(r == 8'h42, "R9 second word value", r, 8'h42);
      chk(tx_empty == 1'b1, "R9 plain read leaves tx_empty", tx_empty, 1);
      repeat (40) @(negedge clk);
      chk(rx_full == 1'b0 && sclk_pri == 1'b1, "R9 no frame after plain read", {rx_full, sclk_pri}, 2'b01);

      // R11 external clock
      cfg_ext_clk = 1'b1; cfg_multi_pin = 1'b1; cfg_alt_sel = 1'b1;
      cfg_ckpol = 0; cfg_msb_first = 0; cfg_invert = 0;
      sclk_in = 1'b1;
      repeat (5) @(negedge clk);
      for (int k = 0; k < 16; k++) begin
         sclk_in = ~sclk_in;
         repeat (5) @(negedge clk);
      end
      chk(rx_full == 1'b0 && tx_empty == 1'b1, "R11 edges ignored when empty", {rx_full, tx_empty}, 2'b01);
      ext_frame(8'hC5, 8'h5B, got, bi);
      chk(got == 8'hC5, "R11 external lsb-first transmit", got, 8'hC5);
      chk(bi == 0, "R11 no clock output", bi, 0);
      chk(rx_full == 1'b1 && rx_data == 8'h5B, "R11 external receive", rx_data, 8'h5B);
      host_read(r);
      cfg_ckpol = 1'b1; cfg_msb_first = 1'b1;
      ext_frame(8'h6E, 8'h93, got, bi);
      chk(got == 8'h6E, "R11 R3 external msb-first transmit", got, 8'h6E);
      chk(bi == 0, "R11 no clock output polarity 1", bi, 0);
      chk(rx_data == 8'h93, "R11 R4 external receive msb-first", rx_data, 8'h93);
      host_read(r);

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule